// File: doc/BRIEF.md
# Two-Base First-Level Translation Walker

The block takes a 32-bit virtual address, picks one of two translation table base registers, and fetches the first-level descriptor for that address. A programmable split value N makes the choice. When N is zero, base 0 covers the whole address space. When N is non-zero, base 0 covers only the lowest part of the address space, and its table shrinks to match. Base 1 always uses a full-size table. The descriptor address is latched when the request is accepted. A small state machine then issues a single read on an external memory request/response port and waits for the data.

The returned word is decoded by its two low bits. The result is one of the following:
- a translation fault;
- a 1 MB section, from which the block forms the physical address directly;
- a coarse or fine second-level table pointer, returned as a table base with its own status code.

A memory error ends the walk with an external-abort code. Configuration writes for both bases and N take effect only for requests accepted after the write.

Top module: `ttb_walker`

## Requirements
- R1: After reset, N is 0, both bases are 0, `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: With N = 0, every request uses base 0. With N > 0, base 0 is used when VA bits [31:32-N] are all zero, and base 1 otherwise. `done_sel` reports the base used (0 or 1).
- R3: With base 0, the descriptor address is base0[31:14-N], then VA[31-N:20], then two zero bits.
- R4: With base 1, the descriptor address is base1[31:14], then VA[31:20], then two zero bits.
- R5: Descriptor bits [1:0] = 00 give status 3 (translation fault), with `done_fault` = 1 and `done_pa` = 0. Bits [1:0] = 10 give status 0 (section), with `done_fault` = 0 and `done_pa` = {desc[31:20], VA[19:0]}.
- R6: Descriptor bits [1:0] = 01 give status 1 (coarse table), with `done_pa` = {desc[31:10], 10'b0}. Bits [1:0] = 11 give status 2 (fine table), with `done_pa` = {desc[31:12], 12'b0}. `done_fault` is 0 in both cases.
- R7: A response with `mem_rsp_err` = 1 gives status 4 (external abort), with `done_fault` = 1 and `done_pa` = 0, whatever the data.
- R8: A request is accepted on the clock edge where `req_valid` and `req_ready` are both 1.
  - `mem_req_valid` rises in the next cycle, and `mem_req_addr` stays constant until an edge with `mem_req_ready` = 1.
  - A response is taken from the cycle after that edge onward.
  - `done` is high for exactly the one cycle after the response edge.
  - `req_ready` returns in the following cycle.
- R9: While a walk is in progress, `req_ready` is 0, and `req_valid` has no effect. No extra memory read follows the walk.
- R10: Writes to base 0, base 1 or N affect only requests accepted after the write edge. A write in the same cycle as an acceptance is not seen by that request.
- R11: A response that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address of the request |
| req_ready | output | 1 | High when a request can be accepted |
| cfg_we_base0 | input | 1 | Write strobe for base 0 |
| cfg_we_base1 | input | 1 | Write strobe for base 1 |
| cfg_we_split | input | 1 | Write strobe for N (taken from the low bits of the write data) |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read ended in error |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Result is a fault (status 3 or 4) |
| done_status | output | 3 | 0 section, 1 coarse, 2 fine, 3 translation fault, 4 external abort |
| done_sel | output | 1 | Base register used |
| done_pa | output | 32 | Physical address or table base |

## Verification
The descriptor read appears one cycle after acceptance, and it holds until the first edge that has `mem_req_ready` = 1. The result pulse comes one cycle after the edge that carries the response, and `req_ready` returns in the cycle after that. The bench keeps a behavioural model that advances on each rising edge, using the same inputs the design sees. It compares every output with the model on the falling edge that follows, so each result is checked exactly in the cycle it is due. Delayed handshakes, responses that arrive early, a request held high through a walk, and configuration writes during and at acceptance all shift these cycles. The model follows each of those shifts.

// File: rtl/ttb_walker.sv
module ttb_walker #(
  parameter int NW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  output logic        req_ready,
  input  logic        cfg_we_base0,
  input  logic        cfg_we_base1,
  input  logic        cfg_we_split,
  input  logic [31:0] cfg_wdata,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic        done_fault,
  output logic [2:0]  done_status,
  output logic        done_sel,
  output logic [31:0] done_pa
);
  localparam logic [2:0] ST_SECTION = 3'd0;
  localparam logic [2:0] ST_COARSE  = 3'd1;
  localparam logic [2:0] ST_FINE    = 3'd2;
  localparam logic [2:0] ST_XLAT    = 3'd3;
  localparam logic [2:0] ST_ABORT   = 3'd4;
  localparam int TBL_SHIFT = 14;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t        state_q;
  logic [31:0]   base0_q, base1_q;
  logic [NW-1:0] split_q;
  logic [31:0]   addr_q;
  logic [19:0]   va_lo_q;
  logic          sel_q;
  logic [2:0]    status_q;
  logic [31:0]   pa_q;

  wire [31:0] hi_mask   = ~(32'hFFFF_FFFF >> split_q);
  wire        use_b1    = |(req_va & hi_mask);
  wire [31:0] tbl0_mask = 32'hFFFF_FFFF << (TBL_SHIFT - int'(split_q));
  wire [11:0] idx0      = req_va[31:20] & (12'hFFF >> split_q);
  wire [31:0] addr_b0   = (base0_q & tbl0_mask) | {18'b0, idx0, 2'b00};
  wire [31:0] addr_b1   = {base1_q[31:TBL_SHIFT], req_va[31:20], 2'b00};
  wire        unused_desc_bits = ^mem_rsp_data[9:2];

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = addr_q;
  assign done          = (state_q == S_DONE);
  assign done_status   = status_q;
  assign done_fault    = (status_q == ST_XLAT) || (status_q == ST_ABORT);
  assign done_sel      = sel_q;
  assign done_pa       = pa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base0_q <= '0;
      base1_q <= '0;
      split_q <= '0;
    end else begin
      if (cfg_we_base0) base0_q <= cfg_wdata;
      if (cfg_we_base1) base1_q <= cfg_wdata;
      if (cfg_we_split) split_q <= cfg_wdata[NW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      va_lo_q  <= '0;
      sel_q    <= 1'b0;
      status_q <= ST_SECTION;
      pa_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          state_q <= S_ISSUE;
          sel_q   <= use_b1;
          addr_q  <= use_b1 ? addr_b1 : addr_b0;
          va_lo_q <= req_va[19:0];
        end
        S_ISSUE: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          state_q <= S_DONE;
          if (mem_rsp_err) begin
            status_q <= ST_ABORT;
            pa_q     <= '0;
          end else begin
            case (mem_rsp_data[1:0])
              2'b00: begin status_q <= ST_XLAT;    pa_q <= '0; end
              2'b10: begin status_q <= ST_SECTION; pa_q <= {mem_rsp_data[31:20], va_lo_q}; end
              2'b01: begin status_q <= ST_COARSE;  pa_q <= {mem_rsp_data[31:10], 10'b0}; end
              default: begin status_q <= ST_FINE;  pa_q <= {mem_rsp_data[31:12], 12'b0}; end
            endcase
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ttb_walker_chk.sv
module ttb_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        done_fault,
  input logic [31:0] done_pa
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid);
  assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !done);
  assert_fault_pa_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> done_pa == 32'h0);
  assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
endmodule

bind ttb_walker ttb_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .done_fault(done_fault),
  .done_pa(done_pa)
);

// File: tb/ttb_walker_test.sv
module ttb_walker_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cfg_we_base0 = 0, cfg_we_base1 = 0, cfg_we_split = 0;
  logic [31:0] req_va = 0, cfg_wdata = 0, mem_rsp_data = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_err = 0;
  logic req_ready, mem_req_valid, done, done_fault, done_sel;
  logic [31:0] mem_req_addr, done_pa;
  logic [2:0] done_status;

  int nchk = 0, nfail = 0;
  bit running = 0;
  string tag = "R1";

  int m_state = 0, m_n = 0, m_status = 0;
  logic [31:0] m_b0 = 0, m_b1 = 0, m_addr = 0, m_va = 0, m_pa = 0;
  bit m_sel = 0;

  always #10 clk = ~clk;

  ttb_walker uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s (%s) %s actual=%h expected=%h", req, tag, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_n = 0; m_b0 = 0; m_b1 = 0;
    end else begin
      case (m_state)
        0: if (req_valid) begin
          logic [31:0] tsz;
          m_va = req_va;
          m_sel = (m_n != 0) && ((req_va >> (32 - m_n)) != 0);
          tsz = 32'd16384 >> m_n;
          if (m_sel) m_addr = (m_b1 - (m_b1 % 32'd16384)) + ((req_va >> 20) << 2);
          else       m_addr = (m_b0 - (m_b0 % tsz)) + ((req_va >> 20) << 2);
          m_state = 1;
        end
        1: if (mem_req_ready) m_state = 2;
        2: if (mem_rsp_valid) begin
          m_state = 3;
          if (mem_rsp_err) begin m_status = 4; m_pa = 0; end
          else case (mem_rsp_data % 4)
            0: begin m_status = 3; m_pa = 0; end
            2: begin m_status = 0; m_pa = (mem_rsp_data & 32'hFFF0_0000) | (m_va & 32'h000F_FFFF); end
            1: begin m_status = 1; m_pa = mem_rsp_data - (mem_rsp_data % 1024); end
            default: begin m_status = 2; m_pa = mem_rsp_data - (mem_rsp_data % 4096); end
          endcase
        end
        default: m_state = 0;
      endcase
      if (cfg_we_base0) m_b0 = cfg_wdata;
      if (cfg_we_base1) m_b1 = cfg_wdata;
      if (cfg_we_split) m_n = int'(cfg_wdata[2:0]);
    end
  end

  always @(negedge clk) if (running) begin
    chk(req_ready == (m_state == 0), "R8", "req_ready", {31'b0, req_ready}, {31'b0, m_state == 0});
    chk(mem_req_valid == (m_state == 1), "R9", "mem_req_valid", {31'b0, mem_req_valid}, {31'b0, m_state == 1});
    if (m_state == 1)
      chk(mem_req_addr == m_addr, m_sel ? "R4" : "R3", "mem_req_addr", mem_req_addr, m_addr);
    chk(done == (m_state == 3), "R8", "done", {31'b0, done}, {31'b0, m_state == 3});
    if (m_state == 3) begin
      chk(done_sel == m_sel, "R2", "done_sel", {31'b0, done_sel}, {31'b0, m_sel});
      chk(done_status == m_status[2:0],
          m_status == 4 ? "R7" : (m_status == 1 || m_status == 2) ? "R6" : "R5",
          "done_status", {29'b0, done_status}, m_status);
      chk(done_fault == (m_status >= 3), "R5", "done_fault", {31'b0, done_fault}, {31'b0, m_status >= 3});
      chk(done_pa == m_pa, m_status == 4 ? "R7" : "R5", "done_pa", done_pa, m_pa);
    end
  end

  task automatic quiet;
    cfg_we_base0 = 0; cfg_we_base1 = 0; cfg_we_split = 0;
    mem_rsp_valid = 0; mem_rsp_err = 0;
  endtask

  task automatic cfg(input int which, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_wdata = d;
    cfg_we_base0 = (which == 0); cfg_we_base1 = (which == 1); cfg_we_split = (which == 2);
    @(negedge clk); #1 quiet();
  endtask

  // mode: 0 plain, 1 request held (R9), 2 early response (R11),
  // 3 config write mid-walk (R10), 4 config write at acceptance (R10)
  task automatic walk(input logic [31:0] va, input logic [31:0] d, input bit e,
                      input int rw, input int sw, input int mode);
    @(negedge clk); #1;
    req_valid = 1; req_va = va;
    if (mode == 4) begin cfg_we_base0 = 1; cfg_wdata = 32'h7777_0000; end
    @(negedge clk); #1;
    quiet();
    if (mode != 1) req_valid = 0;
    if (mode == 3) begin cfg_we_base0 = 1; cfg_we_split = 1; cfg_wdata = 32'h0; end
    if (mode == 2) begin mem_rsp_valid = 1; mem_rsp_data = 32'hFFFF_FFFE; end
    for (int i = 0; i < rw; i++) begin
      mem_req_ready = 0;
      @(negedge clk); #1 quiet();
    end
    mem_req_ready = 1;
    @(negedge clk); #1 quiet();
    mem_req_ready = 0;
    for (int i = 0; i < sw; i++) begin
      @(negedge clk); #1;
    end
    mem_rsp_valid = 1; mem_rsp_data = d; mem_rsp_err = e; req_valid = 0;
    @(negedge clk); #1 quiet();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready in reset", {31'b0, req_ready}, 1);
    chk(mem_req_valid == 0, "R1", "mem_req_valid in reset", {31'b0, mem_req_valid}, 0);
    chk(done == 0, "R1", "done in reset", {31'b0, done}, 0);
    #1 rst_n = 1; running = 1;

    tag = "R1"; walk(32'h8010_0000, 32'h4560_0002, 0, 0, 0, 0);
    cfg(0, 32'h1234_5678);
    cfg(1, 32'hABCD_EFFF);
    tag = "R2"; walk(32'hFFF1_2345, 32'hCAFE_1002, 0, 0, 0, 0);
    cfg(2, 32'd2);
    tag = "R3"; walk(32'h3FF0_0000, 32'h1111_1401, 0, 1, 0, 0);
    tag = "R4"; walk(32'h4000_0000, 32'h2222_2BCF, 0, 0, 1, 0);
    cfg(2, 32'd6);
    tag = "R3"; walk(32'h03F0_0ABC, 32'h0BC0_0002, 0, 0, 0, 0);
    tag = "R4"; walk(32'h0400_0000, 32'h0000_0000, 0, 0, 0, 0);
    cfg(2, 32'd7);
    tag = "R2"; walk(32'h01F0_0000, 32'h5555_5403, 0, 0, 0, 0);
    tag = "R5"; walk(32'h0000_0000, 32'hFFFF_FFFC, 0, 0, 0, 0);
    tag = "R7"; walk(32'h0210_0000, 32'h8000_0002, 1, 0, 0, 0);
    tag = "R8"; walk(32'h0123_4567, 32'h9990_0002, 0, 3, 4, 0);
    tag = "R9"; walk(32'hF000_0000, 32'h7000_0001, 0, 2, 2, 1);
    tag = "R11"; walk(32'h0000_0000, 32'h3000_0002, 0, 2, 1, 2);
    tag = "R10"; walk(32'hF000_0000, 32'h0000_0002, 0, 1, 0, 3);
    tag = "R10"; walk(32'hF000_0000, 32'h0000_0002, 0, 0, 0, 4);
    tag = "R10"; walk(32'hF010_0000, 32'h0000_0003, 0, 0, 0, 0);
    cfg(2, 32'd1);
    tag = "R2"; walk(32'h8000_0000, 32'hABC0_0001, 0, 0, 0, 0);
    tag = "R6"; walk(32'h7FF0_0000, 32'hABCD_E003, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    #(20 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule